// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block turns a 32-bit software-interrupt request word, written by one of up to eight CPUs, into pending state on the CPUs it selects. Each target CPU holds its own copy of the state for every one of sixteen interrupt IDs. That copy has two parts: a pending latch, and a mask recording which CPUs have asked for the interrupt. A target CPU can see who raised an interrupt, and the pending state stays set until every one of those requesters has been cleared.

A single access port serves three address spaces:

- **Request register.** Writing it raises interrupts. Reading it returns zero.
- **Set window.** Sixteen bytes with one byte per ID, mapped onto the accessing CPU's requester masks. A write ORs bits into the mask.
- **Clear window.** The same sixteen bytes. A write removes bits from the mask.

Both windows accept byte and word accesses. The pending latches of all CPUs are brought out as one flat vector for the next stage, which arbitrates priority and handles acknowledge.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset every pending bit and every requester mask is zero, and `rd_data_o` reads zero.
- R2: A request write (`acc_space_i`=00) takes the ID from bits [3:0], the explicit target list from bits [23:16] and the filter mode from bits [25:24]. In mode 0, each listed CPU becomes a target.
- R3: In mode 1, every online CPU except the requester becomes a target.
- R4: In mode 2, only the requester becomes a target.
- R5: In mode 3, the request write is dropped and no pending bit changes.
- R6: For each target, the request sets the pending bit at `pend_o[cpu*16+id]` and ORs the requester's bit (bit `acc_cpu_i`) into that target's mask for the ID. Pending is set exactly when the mask is nonzero.
- R7: A set-window write (`acc_space_i`=01) ORs each written byte into the mask of the matching ID. Pending is set when the resulting mask is nonzero, so writing a zero byte leaves the state unchanged.
- R8: A clear-window write (`acc_space_i`=10) removes the written bits from the mask. Pending is cleared only when the mask becomes zero.
- R9: A window read returns masks one byte per ID. A word access (`acc_word_i`=1) covers the IDs `{addr[3:2],00}`+0..3 in byte lanes 0..3 and ignores `addr[1:0]`. A byte access covers ID `addr` in bits [7:0]. The read data appears on `rd_data_o` one cycle after the read, and the upper bytes of a byte read are zero.
- R10: A read of the request register returns zero.
- R11: Window accesses act only on the copy that belongs to `acc_cpu_i`. The other CPUs' state is unchanged.
- R12: A target CPU whose index is not below `online_i` is never selected, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| online_i | input | 4 | Number of online CPUs (1..8) |
| acc_valid_i | input | 1 | Access strobe |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_space_i | input | 2 | 00 request, 01 set window, 10 clear window, 11 none |
| acc_cpu_i | input | 3 | Index of the accessing CPU |
| acc_addr_i | input | 4 | Byte address inside a window |
| acc_word_i | input | 1 | 1 = 32-bit access, 0 = 8-bit access |
| acc_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, registered |
| pend_o | output | 128 | Pending latches, bit cpu*16+id |

## Verification
Every write takes effect at the clock edge that accepts it, so the pending vector and the masks show the new state one cycle after the strobe. A read returns its data on `rd_data_o` one cycle after the strobe. The data comes from the masks as they stood before that edge. The bench drives each access at a falling edge and updates its model just after the accepting rising edge. It compares the pending vector with the model at every falling edge, and checks read data at the falling edge that follows the accepting edge.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  typedef enum logic [1:0] {
    SP_REQ  = 2'b00,
    SP_SET  = 2'b01,
    SP_CLR  = 2'b10,
    SP_NONE = 2'b11
  } space_e;

  typedef enum logic [1:0] {
    FM_LIST   = 2'b00,
    FM_OTHERS = 2'b01,
    FM_SELF   = 2'b10,
    FM_RSVD   = 2'b11
  } fmode_e;

  localparam int unsigned TGT_LSB  = 16;
  localparam int unsigned MODE_LSB = 24;
endpackage

// File: rtl/sgi_req_decode.sv
module sgi_req_decode #(
  parameter int unsigned NUM_CPUS = 8,
  parameter int unsigned NUM_IDS  = 16,
  localparam int unsigned CPU_W = $clog2(NUM_CPUS),
  localparam int unsigned CNT_W = $clog2(NUM_CPUS + 1),
  localparam int unsigned ID_W  = $clog2(NUM_IDS)
) (
  input  logic                valid_i,
  input  logic [ID_W-1:0]     id_i,
  input  logic [NUM_CPUS-1:0] list_i,
  input  logic [1:0]          mode_i,
  input  logic [CPU_W-1:0]    cpu_i,
  input  logic [CNT_W-1:0]    online_i,
  output logic [NUM_IDS-1:0]  id_hit_o,
  output logic [NUM_CPUS-1:0] tgt_o,
  output logic [NUM_CPUS-1:0] src_bit_o
);
  import sgi_pkg::*;

  logic [NUM_CPUS-1:0] online_mask;
  logic                accept;

  always_comb begin
    for (int c = 0; c < NUM_CPUS; c++) begin
      online_mask[c] = (c < int'(online_i));
      src_bit_o[c]   = (c == int'(cpu_i));
    end
  end

  always_comb begin
    unique case (fmode_e'(mode_i))
      FM_LIST:   tgt_o = list_i & online_mask;
      FM_OTHERS: tgt_o = online_mask & ~src_bit_o;
      FM_SELF:   tgt_o = online_mask & src_bit_o;
      default:   tgt_o = '0;
    endcase
  end

  assign accept = valid_i && (fmode_e'(mode_i) != FM_RSVD);

  always_comb begin
    for (int i = 0; i < NUM_IDS; i++) id_hit_o[i] = accept && (i == int'(id_i));
  end
endmodule

// File: rtl/sgi_win_decode.sv
module sgi_win_decode #(
  parameter int unsigned NUM_IDS = 16,
  localparam int unsigned AW = $clog2(NUM_IDS)
) (
  input  logic [AW-1:0]             addr_i,
  input  logic                      word_i,
  output logic [NUM_IDS-1:0]        lane_en_o,
  output logic [NUM_IDS-1:0][1:0]   lane_pos_o
);
  // word access: IDs of the aligned group of four, lane = ID mod 4
  always_comb begin
    for (int i = 0; i < NUM_IDS; i++) begin
      lane_en_o[i]  = 1'b0;
      lane_pos_o[i] = 2'd0;
      if (word_i) begin
        if ((i / 4) == int'(addr_i[AW-1:2])) begin
          lane_en_o[i]  = 1'b1;
          lane_pos_o[i] = 2'(i % 4);
        end
      end else if (i == int'(addr_i)) begin
        lane_en_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sgi_cell.sv
module sgi_cell #(
  parameter int unsigned NUM_CPUS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_hit_i,
  input  logic [NUM_CPUS-1:0] req_bit_i,
  input  logic                set_i,
  input  logic                clr_i,
  input  logic [NUM_CPUS-1:0] byte_i,
  output logic [NUM_CPUS-1:0] src_o,
  output logic                pend_o
);
  logic [NUM_CPUS-1:0] src_q, set_nxt, clr_nxt;

  assign set_nxt = src_q | byte_i;
  assign clr_nxt = src_q & ~byte_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      pend_o <= 1'b0;
    end else if (req_hit_i) begin
      src_q  <= src_q | req_bit_i;
      pend_o <= 1'b1;
    end else if (set_i) begin
      src_q <= set_nxt;
      if (set_nxt != '0) pend_o <= 1'b1;
    end else if (clr_i) begin
      src_q <= clr_nxt;
      if (clr_nxt == '0) pend_o <= 1'b0;
    end
  end

  assign src_o = src_q;
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch #(
  parameter int unsigned NUM_CPUS = 8,
  parameter int unsigned NUM_IDS  = 16,
  localparam int unsigned CPU_W = $clog2(NUM_CPUS),
  localparam int unsigned CNT_W = $clog2(NUM_CPUS + 1),
  localparam int unsigned AW    = $clog2(NUM_IDS),
  localparam int unsigned PW    = NUM_CPUS * NUM_IDS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] online_i,
  input  logic             acc_valid_i,
  input  logic             acc_write_i,
  input  logic [1:0]       acc_space_i,
  input  logic [CPU_W-1:0] acc_cpu_i,
  input  logic [AW-1:0]    acc_addr_i,
  input  logic             acc_word_i,
  input  logic [31:0]      acc_wdata_i,
  output logic [31:0]      rd_data_o,
  output logic [PW-1:0]    pend_o
);
  import sgi_pkg::*;

  logic                        req_wr, set_wr, clr_wr, win_rd;
  logic [NUM_IDS-1:0]          id_hit, lane_en;
  logic [NUM_IDS-1:0][1:0]     lane_pos;
  logic [NUM_CPUS-1:0]         tgt, src_bit;
  logic [NUM_CPUS-1:0]         lane_byte [NUM_IDS];
  logic [NUM_CPUS-1:0]         src_q [NUM_CPUS][NUM_IDS];
  logic [PW*NUM_CPUS-1:0]      src_flat;
  logic [31:0]                 rd_nxt;

  assign req_wr = acc_valid_i && acc_write_i && (space_e'(acc_space_i) == SP_REQ);
  assign set_wr = acc_valid_i && acc_write_i && (space_e'(acc_space_i) == SP_SET);
  assign clr_wr = acc_valid_i && acc_write_i && (space_e'(acc_space_i) == SP_CLR);
  assign win_rd = (space_e'(acc_space_i) == SP_SET) || (space_e'(acc_space_i) == SP_CLR);

  sgi_req_decode #(.NUM_CPUS(NUM_CPUS), .NUM_IDS(NUM_IDS)) u_req (
    .valid_i   (req_wr),
    .id_i      (acc_wdata_i[AW-1:0]),
    .list_i    (acc_wdata_i[TGT_LSB +: NUM_CPUS]),
    .mode_i    (acc_wdata_i[MODE_LSB +: 2]),
    .cpu_i     (acc_cpu_i),
    .online_i  (online_i),
    .id_hit_o  (id_hit),
    .tgt_o     (tgt),
    .src_bit_o (src_bit)
  );

  sgi_win_decode #(.NUM_IDS(NUM_IDS)) u_win (
    .addr_i     (acc_addr_i),
    .word_i     (acc_word_i),
    .lane_en_o  (lane_en),
    .lane_pos_o (lane_pos)
  );

  always_comb begin
    for (int i = 0; i < NUM_IDS; i++)
      lane_byte[i] = acc_wdata_i[8*int'(lane_pos[i]) +: NUM_CPUS];
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic own;
    assign own = (int'(acc_cpu_i) == c);
    for (genvar i = 0; i < NUM_IDS; i++) begin : g_id
      sgi_cell #(.NUM_CPUS(NUM_CPUS)) u_cell (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .req_hit_i (id_hit[i] && tgt[c]),
        .req_bit_i (src_bit),
        .set_i     (set_wr && own && lane_en[i]),
        .clr_i     (clr_wr && own && lane_en[i]),
        .byte_i    (lane_byte[i]),
        .src_o     (src_q[c][i]),
        .pend_o    (pend_o[c*NUM_IDS + i])
      );
      assign src_flat[(c*NUM_IDS + i)*NUM_CPUS +: NUM_CPUS] = src_q[c][i];
    end
  end

  always_comb begin
    rd_nxt = '0;
    if (win_rd) begin
      for (int i = 0; i < NUM_IDS; i++)
        if (lane_en[i]) rd_nxt[8*int'(lane_pos[i]) +: NUM_CPUS] = src_q[acc_cpu_i][i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else if (acc_valid_i && !acc_write_i) rd_data_o <= rd_nxt;
  end
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
  parameter int unsigned NUM_CPUS = 8,
  parameter int unsigned NUM_IDS  = 16,
  localparam int unsigned CPU_W = $clog2(NUM_CPUS),
  localparam int unsigned CNT_W = $clog2(NUM_CPUS + 1),
  localparam int unsigned PW    = NUM_CPUS * NUM_IDS
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [CNT_W-1:0]       online_i,
  input logic                   acc_valid_i,
  input logic                   acc_write_i,
  input logic [1:0]             acc_space_i,
  input logic [CPU_W-1:0]       acc_cpu_i,
  input logic [1:0]             mode_i,
  input logic [31:0]            rd_data_o,
  input logic [PW-1:0]          pend_o,
  input logic [PW*NUM_CPUS-1:0] src_flat
);
  logic [PW-1:0] off_mask, other_mask, mismatch;
  logic req_w, set_w, clr_w;

  always_comb begin
    for (int c = 0; c < NUM_CPUS; c++)
      for (int i = 0; i < NUM_IDS; i++) begin
        off_mask[c*NUM_IDS+i]   = (c >= int'(online_i));
        other_mask[c*NUM_IDS+i] = (c != int'(acc_cpu_i));
        mismatch[c*NUM_IDS+i]   = pend_o[c*NUM_IDS+i] !=
                                  (|src_flat[(c*NUM_IDS+i)*NUM_CPUS +: NUM_CPUS]);
      end
  end

  assign req_w = acc_valid_i && acc_write_i && acc_space_i == 2'b00;
  assign set_w = acc_valid_i && acc_write_i && acc_space_i == 2'b01;
  assign clr_w = acc_valid_i && acc_write_i && acc_space_i == 2'b10;

  // R6
  pend_vs_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch == '0);
  // R5
  rsvd_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_w && mode_i == 2'b11 |=> $stable(pend_o));
  // R10
  req_raz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && !acc_write_i && acc_space_i == 2'b00 |=> rd_data_o == '0);
  // R12
  offline_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_w |=> ((pend_o & ~$past(pend_o)) & $past(off_mask)) == '0);
  // R7
  set_no_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_w |=> (pend_o & $past(pend_o)) == $past(pend_o));
  // R8
  clr_no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_w |=> (pend_o & ~$past(pend_o)) == '0);
  // R11
  win_own_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_w || clr_w |=> ((pend_o ^ $past(pend_o)) & $past(other_mask)) == '0);
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CPUS(NUM_CPUS), .NUM_IDS(NUM_IDS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .online_i    (online_i),
  .acc_valid_i (acc_valid_i),
  .acc_write_i (acc_write_i),
  .acc_space_i (acc_space_i),
  .acc_cpu_i   (acc_cpu_i),
  .mode_i      (acc_wdata_i[25:24]),
  .rd_data_o   (rd_data_o),
  .pend_o      (pend_o),
  .src_flat    (src_flat)
);

// File: tb/sim_sgi_dispatch.sv
`timescale 1ns/1ps
module sim_sgi_dispatch;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   online = 4'd4;
  logic         valid = 1'b0, write = 1'b0, word = 1'b0;
  logic [1:0]   space = 2'b11;
  logic [2:0]   cpu = '0;
  logic [3:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rd_data;
  logic [127:0] pend;

  int  tests = 0, fails = 0;
  bit  done = 1'b0;
  int  src_m [8][16];

  always #2.5 clk = ~clk;

  sgi_dispatch u0 (
    .clk_i(clk), .rst_ni(rst_n), .online_i(online),
    .acc_valid_i(valid), .acc_write_i(write), .acc_space_i(space),
    .acc_cpu_i(cpu), .acc_addr_i(addr), .acc_word_i(word),
    .acc_wdata_i(wdata), .rd_data_o(rd_data), .pend_o(pend)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] model_pend();
    logic [127:0] p = '0;
    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 16; i++) p[c*16+i] = (src_m[c][i] != 0);
    return p;
  endfunction

  // R6 compare pending against the model on every clock
  always @(negedge clk) begin
    if (rst_n && !done) check(pend === model_pend(), "R6 pend vector", pend, model_pend());
  end

  task automatic acc(input bit wr, input logic [1:0] sp, input int c, input int a,
                     input bit wd, input logic [31:0] d, input string tag);
    logic [31:0] exp_rd = '0;
    @(negedge clk);
    valid = 1'b1; write = wr; space = sp; cpu = 3'(c); addr = 4'(a); word = wd; wdata = d;
    @(posedge clk);
    if (!wr) begin
      if (sp == 2'b01 || sp == 2'b10) begin
        if (wd) for (int k = 0; k < 4; k++) exp_rd[8*k +: 8] = 8'(src_m[c][(a & 12) + k]);
        else exp_rd[7:0] = 8'(src_m[c][a]);
      end
    end else if (sp == 2'b00) begin
      int id = int'(d[3:0]);
      int om = (1 << int'(online)) - 1;
      int tg;
      case (d[25:24])
        2'b00: tg = int'(d[23:16]) & om;
        2'b01: tg = om & ~(1 << c);
        2'b10: tg = om & (1 << c);
        default: tg = 0;
      endcase
      for (int t = 0; t < 8; t++) if (tg[t]) src_m[t][id] |= (1 << c);
    end else if (sp == 2'b01 || sp == 2'b10) begin
      for (int k = 0; k < (wd ? 4 : 1); k++) begin
        int id = wd ? ((a & 12) + k) : a;
        int b = int'(d[8*k +: 8]);
        if (sp == 2'b01) src_m[c][id] |= b;
        else src_m[c][id] &= ~b;
      end
    end
    @(negedge clk);
    valid = 1'b0;
    if (!wr) check(rd_data === exp_rd, tag, 128'(rd_data), 128'(exp_rd));
  endtask

  task automatic chk_pend(input int c, input int i, input bit exp, input string tag);
    check(pend[c*16+i] === exp, tag, 128'(pend[c*16+i]), 128'(exp));
  endtask

  initial begin
    for (int c = 0; c < 8; c++) for (int i = 0; i < 16; i++) src_m[c][i] = 0;
    repeat (3) @(negedge clk);
    check(pend === '0, "R1 reset pend", pend, '0);
    check(rd_data === '0, "R1 reset rd", 128'(rd_data), '0);
    rst_n = 1'b1;
    // R2 R12: mode 0 from cpu1, id5, list bits 0,2,5,7, four online
    acc(1, 2'b00, 1, 0, 1, 32'h00A5_0005, "R2");
    chk_pend(0, 5, 1, "R2 listed cpu0");
    chk_pend(2, 5, 1, "R2 listed cpu2");
    chk_pend(5, 5, 0, "R12 offline cpu5");
    chk_pend(7, 5, 0, "R12 offline cpu7");
    acc(0, 2'b01, 0, 5, 0, 0, "R9 byte read id5");
    check(rd_data === 32'h02, "R6 requester bit", 128'(rd_data), 128'h02);
    // R3: mode 1 from cpu2, id3
    acc(1, 2'b00, 2, 0, 1, 32'h0100_0003, "R3");
    chk_pend(2, 3, 0, "R3 self excluded");
    chk_pend(1, 3, 1, "R3 other cpu1");
    acc(0, 2'b10, 3, 1, 1, 0, "R9 word read ids0-3");
    check(rd_data === 32'h0400_0000, "R9 lane order", 128'(rd_data), 128'h0400_0000);
    // R4: mode 2 from cpu3, id9
    acc(1, 2'b00, 3, 0, 1, 32'h02FF_0009, "R4");
    chk_pend(3, 9, 1, "R4 self");
    chk_pend(0, 9, 0, "R4 not listed");
    // R5: reserved mode dropped
    acc(1, 2'b00, 0, 0, 1, 32'h03FF_0001, "R5");
    for (int c = 0; c < 8; c++) chk_pend(c, 1, 0, "R5 dropped");
    // R10
    acc(0, 2'b00, 3, 0, 1, 0, "R10 request reads zero");
    // R7: set window word write on cpu1 ids 8..11
    acc(1, 2'b01, 1, 9, 1, 32'h0080_0011, "R7");
    chk_pend(1, 8, 1, "R7 id8 set");
    chk_pend(1, 9, 0, "R7 zero byte no effect");
    chk_pend(1, 10, 1, "R7 id10 set");
    acc(0, 2'b01, 1, 8, 1, 0, "R7 readback");
    check(rd_data === 32'h0080_0011, "R7 masks", 128'(rd_data), 128'h0080_0011);
    acc(1, 2'b01, 1, 12, 0, 0, "R7 zero byte");
    chk_pend(1, 12, 0, "R7 zero byte stays idle");
    // R8: partial then full clear
    acc(1, 2'b10, 0, 5, 0, 32'h01, "R8");
    chk_pend(0, 5, 1, "R8 other bit keeps pending");
    acc(1, 2'b10, 0, 5, 0, 32'h02, "R8");
    chk_pend(0, 5, 0, "R8 last bit clears");
    chk_pend(2, 5, 1, "R11 cpu2 copy untouched");
    // R11: set on cpu2 only
    acc(1, 2'b01, 2, 14, 0, 32'h40, "R11");
    chk_pend(2, 14, 1, "R11 own copy");
    chk_pend(1, 14, 0, "R11 other copy");
    // R3 R2 with eight online
    online = 4'd8;
    acc(1, 2'b00, 7, 0, 1, 32'h0100_000F, "R3");
    chk_pend(6, 15, 1, "R3 all but self");
    chk_pend(7, 15, 0, "R3 self excluded");
    acc(1, 2'b00, 4, 0, 1, 32'h00FF_0002, "R2");
    chk_pend(7, 2, 1, "R2 full list");
    // R8 word clear of cpu1 ids 8..11
    acc(1, 2'b10, 1, 8, 1, 32'hFFFF_FFFF, "R8");
    chk_pend(1, 8, 0, "R8 word clear");
    chk_pend(1, 10, 0, "R8 word clear");
    acc(0, 2'b01, 7, 2, 0, 0, "R9 byte read id2");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule